// File: doc/BRIEF.md
# Single-Level 2D Reversible Wavelet Tile Engine

The engine applies one level of the reversible 5/3 integer wavelet transform to a square tile of `TILE_N` x `TILE_N` signed samples, all held in one on-chip memory for the whole operation. A host fills the memory through a write port while the engine is idle and pulses `start`. The engine then works on one line at a time. For each line it reads the line into a line register, runs both lifting steps on it into a second holding register, and writes the result back in band order. It does every column first and every row afterwards. At the end it pulses `done`, and the host reads the coefficients back through a read port with a one-cycle latency.

After the column pass the top half of every column holds low-pass results and the bottom half holds high-pass results. The row pass then does the same across each row. The tile ends up split into four quadrants: LL at the top left, the horizontal-high band at the top right, the vertical-high band at the bottom left, and HH at the bottom right. Each stored word is two bits wider than a sample, one guard bit per one-dimensional pass, so no coefficient can overflow.

Top module: `dwt2d_tile`

## Requirements
- R1: While `busy` is low, a cycle with `wr_en` high stores `wr_data`, sign-extended, at word `wr_addr`. The address of row r, column c is r*TILE_N+c. `rd_data` shows the word at `rd_addr` one clock later.
- R2: For every odd index i in a line, the high-pass value is x[i] - floor((x[i-1]+x[i+1])/2). At the last index, x[TILE_N] is replaced by x[TILE_N-2].
- R3: For every even index i in a line, the low-pass value is x[i] + floor((d[i-1]+d[i+1]+2)/4), where d are the high-pass values. At index 0, d[-1] is replaced by d[1].
- R4: All columns are transformed before any row. Within each line, the low results from even indices are placed first, at positions 0..TILE_N/2-1, and the odd results follow. A constant tile therefore leaves its value in every LL word and zero in every other word.
- R5: After the column pass every coefficient fits in SAMPLE_W+1 signed bits. Final coefficients fit in SAMPLE_W+2 bits, the width of `rd_data`, for any input, including alternating extreme values.
- R6: `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle, 2*TILE_N*(2*TILE_N+2) clock edges after the edge that accepted `start`, and `busy` is low from that cycle on.
- R7: Host writes presented while `busy` is high leave the memory unchanged.
- R8: A `start` pulse while `busy` is high is ignored and does not change the completion time.
- R9: During and right after reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform of the stored tile |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | $clog2(TILE_N*TILE_N) | Host write word address (row-major) |
| wr_data | input | SAMPLE_W | Signed sample to store |
| rd_addr | input | $clog2(TILE_N*TILE_N) | Host read word address (row-major) |
| rd_data | output | SAMPLE_W+2 | Signed coefficient, one cycle after `rd_addr` |

## Verification
Two cases are hard to reach from the ports: the mirrored neighbours at both ends of every line, and the widest growth of a coefficient. Neither can be observed until both passes have combined. The stimulus table covers them with ramps, edge spikes and an alternating full-scale checkerboard. A reference model in the bench, built on its own floor division and mirror index, predicts every coefficient. Host writes and a second `start` are injected in the middle of a run, and the latency and the final coefficients are then checked to show that neither had any effect.

// File: rtl/dwt2d_pkg.sv
package dwt2d_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_FILT = 3'd2,
    ST_DEIL = 3'd3
  } seq_state_t;

  // floor((l + r) / 2) removed from an odd sample
  function automatic int lift_predict(input int odd_v, input int left_v, input int right_v);
    return odd_v - ((left_v + right_v) >>> 1);
  endfunction

  // floor((dl + dr + 2) / 4) added to an even sample
  function automatic int lift_update(input int even_v, input int dl, input int dr);
    return even_v + ((dl + dr + 2) >>> 2);
  endfunction

endpackage

// File: rtl/tile_ram.sv
module tile_ram #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 10,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/line_lift.sv
module line_lift
  import dwt2d_pkg::*;
#(
  parameter int TILE_N = 8,
  parameter int CW     = 10
) (
  input  logic signed [CW-1:0] x [TILE_N],
  output logic signed [CW-1:0] y [TILE_N]
);

  int d [TILE_N];

  for (genvar i = 0; i < TILE_N; i++) begin : g_pred
    if (i % 2 == 1) begin : g_odd
      if (i == TILE_N - 1) begin : g_edge
        assign d[i] = lift_predict(int'(x[i]), int'(x[i-1]), int'(x[i-1]));
      end else begin : g_mid
        assign d[i] = lift_predict(int'(x[i]), int'(x[i-1]), int'(x[i+1]));
      end
    end else begin : g_even
      assign d[i] = int'(x[i]);
    end
  end

  for (genvar i = 0; i < TILE_N; i++) begin : g_upd
    if (i % 2 == 1) begin : g_odd
      assign y[i] = CW'(d[i]);
    end else if (i == 0) begin : g_edge
      assign y[i] = CW'(lift_update(int'(x[i]), d[1], d[1]));
    end else begin : g_mid
      assign y[i] = CW'(lift_update(int'(x[i]), d[i-1], d[i+1]));
    end
  end

endmodule

// File: rtl/dwt_seq.sv
module dwt_seq
  import dwt2d_pkg::*;
#(
  parameter int TILE_N = 8,
  parameter int CW     = 10,
  localparam int AW    = $clog2(TILE_N*TILE_N),
  localparam int LW    = $clog2(TILE_N),
  localparam int CNTW  = $clog2(TILE_N+1),
  localparam int HALF  = TILE_N/2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [AW-1:0]        eng_raddr,
  input  logic [CW-1:0]        ram_rdata,
  output logic                 eng_we,
  output logic [AW-1:0]        eng_waddr,
  output logic [CW-1:0]        eng_wdata,
  output logic signed [CW-1:0] lift_x [TILE_N],
  input  logic signed [CW-1:0] lift_y [TILE_N],
  output logic                 pass_row,
  output logic                 last_write
);

  seq_state_t        state;
  logic [CNTW-1:0]   cnt;
  logic [LW-1:0]     line;
  logic [LW-1:0]     pos;
  logic [LW-1:0]     src;
  logic signed [CW-1:0] ld_buf   [TILE_N];
  logic signed [CW-1:0] filt_buf [TILE_N];
  logic              line_end;
  logic              tile_line_end;

  function automatic logic [AW-1:0] tile_addr(input logic row_mode, input logic [LW-1:0] ln,
                                               input logic [LW-1:0] k);
    if (row_mode) return AW'(ln) * AW'(TILE_N) + AW'(k);
    else          return AW'(k) * AW'(TILE_N) + AW'(ln);
  endfunction

  assign pos           = cnt[LW-1:0];
  assign src           = (pos < LW'(HALF)) ? LW'(pos << 1) : LW'(((pos - LW'(HALF)) << 1) + 1);
  assign line_end      = (state == ST_DEIL) && (cnt == CNTW'(TILE_N-1));
  assign tile_line_end = line_end && (line == LW'(TILE_N-1));
  assign last_write    = tile_line_end && pass_row;

  assign busy      = (state != ST_IDLE);
  assign eng_raddr = tile_addr(pass_row, line, pos);
  assign eng_we    = (state == ST_DEIL);
  assign eng_waddr = tile_addr(pass_row, line, pos);
  assign eng_wdata = filt_buf[src];
  assign lift_x    = ld_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      line     <= '0;
      pass_row <= 1'b0;
      done     <= 1'b0;
      for (int i = 0; i < TILE_N; i++) begin
        ld_buf[i]   <= '0;
        filt_buf[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOAD;
            cnt      <= '0;
            line     <= '0;
            pass_row <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (cnt != '0) ld_buf[LW'(cnt - 1'b1)] <= ram_rdata;
          if (cnt == CNTW'(TILE_N)) begin
            cnt   <= '0;
            state <= ST_FILT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FILT: begin
          filt_buf <= lift_y;
          state    <= ST_DEIL;
        end
        ST_DEIL: begin
          if (line_end) begin
            cnt <= '0;
            if (tile_line_end) begin
              line <= '0;
              if (pass_row) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                pass_row <= 1'b1;
                state    <= ST_LOAD;
              end
            end else begin
              line  <= line + 1'b1;
              state <= ST_LOAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dwt2d_tile.sv
module dwt2d_tile #(
  parameter int TILE_N   = 8,
  parameter int SAMPLE_W = 8,
  localparam int CW      = SAMPLE_W + 2,
  localparam int AW      = $clog2(TILE_N*TILE_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [CW-1:0]       rd_data
);

  logic                 eng_we;
  logic [AW-1:0]        eng_waddr;
  logic [CW-1:0]        eng_wdata;
  logic [AW-1:0]        eng_raddr;
  logic                 host_we_eff;
  logic                 ram_we;
  logic [AW-1:0]        ram_waddr;
  logic [CW-1:0]        ram_wdata;
  logic [AW-1:0]        ram_raddr;
  logic [CW-1:0]        ram_rdata;
  logic signed [CW-1:0] lift_x [TILE_N];
  logic signed [CW-1:0] lift_y [TILE_N];
  logic                 pass_row;
  logic                 last_write;

  assign host_we_eff = wr_en && !busy;
  assign ram_we      = busy ? eng_we    : host_we_eff;
  assign ram_waddr   = busy ? eng_waddr : wr_addr;
  assign ram_wdata   = busy ? eng_wdata : {{(CW-SAMPLE_W){wr_data[SAMPLE_W-1]}}, wr_data};
  assign ram_raddr   = busy ? eng_raddr : rd_addr;
  assign rd_data     = ram_rdata;

  tile_ram #(.DEPTH(TILE_N*TILE_N), .WIDTH(CW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  line_lift #(.TILE_N(TILE_N), .CW(CW)) u_lift (
    .x (lift_x),
    .y (lift_y)
  );

  dwt_seq #(.TILE_N(TILE_N), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .eng_raddr  (eng_raddr),
    .ram_rdata  (ram_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata),
    .lift_x     (lift_x),
    .lift_y     (lift_y),
    .pass_row   (pass_row),
    .last_write (last_write)
  );

endmodule

// File: rtl/dwt2d_tile_chk.sv
module dwt2d_tile_chk #(
  parameter int TILE_N   = 8,
  parameter int SAMPLE_W = 8,
  localparam int CW      = SAMPLE_W + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          host_we_eff,
  input logic          eng_we,
  input logic [CW-1:0] eng_wdata,
  input logic          pass_row,
  input logic          last_write
);

  // column results need only SAMPLE_W+1 bits: top two bits agree
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !pass_row) |-> (eng_wdata[CW-1] == eng_wdata[CW-2]));

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_write |=> (done && !busy));

  assert_host_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_we_eff);

  assert_engine_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_we);

endmodule

bind dwt2d_tile dwt2d_tile_chk #(.TILE_N(TILE_N), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .host_we_eff (host_we_eff),
  .eng_we      (eng_we),
  .eng_wdata   (eng_wdata),
  .pass_row    (pass_row),
  .last_write  (last_write)
);

// File: tb/dwt2d_tile_bench.sv
module dwt2d_tile_bench;
  localparam int PERIOD = 10;
  localparam int N      = 8;
  localparam int SW     = 8;
  localparam int CW     = SW + 2;
  localparam int AW     = $clog2(N*N);
  localparam int LAT    = 2*N*(2*N+2);
  localparam int NVEC   = 5;
  // kind, a, b, inject (0 none, 1 host writes while busy, 2 start while busy)
  localparam int VEC [NVEC][4] = '{
    '{0,  37,   0, 0},
    '{1,  15,  -9, 1},
    '{2,   3,   0, 2},
    '{3,   0,   0, 0},
    '{4, -100, 90, 1}
  };

  logic clk = 0;
  logic rst_n, start, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [SW-1:0] wr_data;
  logic busy, done;
  logic signed [CW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  int ref_t [N][N];
  int la [N];
  int ly [N];

  always #(PERIOD/2) clk = ~clk;

  dwt2d_tile #(.TILE_N(N), .SAMPLE_W(SW)) u_dwt2d_tile (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fdiv(input int a, input int b);
    int q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int mir(input int k);
    if (k < 0) return -k;
    if (k >= N) return 2*N - 2 - k;
    return k;
  endfunction

  function automatic int gen(input int kind, input int a, input int b, input int r, input int c);
    case (kind)
      0: return a;
      1: return a*r + b*c;
      2: return ((r*37 + c*11 + a*5) % 256) - 128;
      3: return ((r + c) % 2 == 0) ? 127 : -128;
      default: return (c == 0 || r == N-1) ? a : b;
    endcase
  endfunction

  // one-dimensional reference: la -> ly in band order
  task automatic ref_line();
    int hp [N];
    int lo [N];
    for (int k = 1; k < N; k += 2) hp[k] = la[k] - fdiv(la[mir(k-1)] + la[mir(k+1)], 2);
    for (int k = 0; k < N; k += 2) lo[k] = la[k] + fdiv(hp[mir(k-1)] + hp[mir(k+1)] + 2, 4);
    for (int j = 0; j < N/2; j++) begin
      ly[j]       = lo[2*j];
      ly[j + N/2] = hp[2*j + 1];
    end
  endtask

  task automatic ref_tile();
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k < N; k++) la[k] = ref_t[k][c];
      ref_line();
      for (int k = 0; k < N; k++) ref_t[k][c] = ly[k];
    end
    for (int r = 0; r < N; r++) begin
      for (int k = 0; k < N; k++) la[k] = ref_t[r][k];
      ref_line();
      for (int k = 0; k < N; k++) ref_t[r][k] = ly[k];
    end
  endtask

  task automatic host_write(input int addr, input int val);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = SW'(val);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic host_read(input int addr, output int val);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic run_vec(input int kind, input int a, input int b, input int inj);
    int cyc, v;
    string tag;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ref_t[r][c] = gen(kind, a, b, r, c);
        host_write(r*N + c, ref_t[r][c]);
      end
    ref_tile();
    @(negedge clk);
    start = 1;
    @(posedge clk);
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 0; wr_en = 0;
      if (done) break;
      if (cyc == 1) chk("R6 busy after start", int'(busy), 1);
      if (inj == 1 && cyc >= 20 && cyc < 30) begin
        wr_en = 1; wr_addr = AW'(cyc); wr_data = SW'(cyc*7 - 60);
      end
      if (inj == 2 && cyc == 60) start = 1;
      if (cyc > LAT + 50) break;
    end
    tag = (inj == 2) ? "R8 latency with extra start" : "R6 latency";
    chk(tag, cyc, LAT);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    chk("R6 busy low after done", int'(busy), 0);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        host_read(r*N + c, v);
        if (inj == 1)      tag = "R7 coefficient after busy writes";
        else if (kind == 3) tag = "R5 coefficient extreme";
        else if (r < N/2 && c < N/2) tag = "R3 R4 LL coefficient";
        else               tag = "R2 R4 high band coefficient";
        chk(tag, v, ref_t[r][c]);
      end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    rst_n = 0; start = 0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", int'(busy), 0);
    chk("R9 done in reset", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 done after reset", int'(done), 0);

    host_write(5, -77);
    host_read(5, v);
    chk("R1 sign-extended readback", v, -77);
    host_write(N*N - 1, 127);
    host_read(N*N - 1, v);
    chk("R1 last word readback", v, 127);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // constant tile: explicit quadrant checks for R4
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) host_write(r*N + c, -50);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    host_read(0, v);                  chk("R4 LL corner of constant tile", v, -50);
    host_read((N/2-1)*N + N/2-1, v);  chk("R4 LL inner corner", v, -50);
    host_read(N/2, v);                chk("R4 high band zero top right", v, 0);
    host_read((N/2)*N, v);            chk("R4 high band zero bottom left", v, 0);
    host_read(N*N - 1, v);            chk("R4 HH zero", v, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule